// File: doc/BRIEF.md
# Sixteen-Bit Two-Operand ALU with Status Flags

This block is the two-operand arithmetic and logic unit of a small 16-bit accumulator-style processor core. On each clock it takes a 4-bit operation code, a source and a destination operand, a byte/word select and the current status flags: carry, zero, negative and overflow. One cycle later it presents the result, a write-enable for the destination, the next value of all four flags and a per-flag mask that shows which flags the operation updated.

Subtraction reuses the adder. The source is inverted and a carry-in is added, so the carry flag reads as "no borrow". Compare and bit-test set flags but do not write the destination. Bit-clear and bit-set write the destination and leave every flag as it was. Decimal add feeds the incoming carry into a chain of packed-BCD digits. In byte mode only the low eight bits take part in the operation.

Top module: `alu16_core`

## Requirements
- R1: All outputs are registered and are due at the first rising clock edge after the inputs are applied. While rst_ni is low, result_o, wr_en_o, flags_o and flag_upd_o are all zero.
- R2: Opcode 0101 computes dst+src and opcode 0110 computes dst+src+C. Both write the destination and update all four flags. C is the carry out of the sign bit, Z is set when the result is zero and N is the sign bit of the result.
- R3: Opcode 1000 computes dst+~src+1 and opcode 0111 computes dst+~src+C. Both write the destination and update all four flags. C is set when no borrow occurs: 10-1 sets C and 5-8 clears it.
- R4: For opcodes 0101, 0110, 0111, 1000 and 1001, V is set exactly when the destination and the effective second addend (src, or ~src for the subtracting opcodes) have the same sign and the result sign differs from it.
- R5: Opcode 1001 computes the same result and flags as opcode 1000, but wr_en_o stays 0.
- R6: Opcode 1010 is a packed-BCD add of dst, src and C. A digit whose binary sum exceeds 9 is corrected by adding 6 and passes a carry to the next digit. C is the carry out of the top digit. N and Z are updated and V keeps its incoming value. Examples: 0x0009+1 gives 0x0010, and 0x0099+1 with C=1 gives 0x0101.
- R7: Opcodes 1100 (dst & ~src) and 1101 (dst | src) write the destination. flag_upd_o is 0000 and flags_o equals the incoming flags.
- R8: Opcode 1111 (dst & src) writes the destination, opcode 1011 (dst & src) does not, and opcode 1110 (dst ^ src) writes it. All three update all four flags. C means the result is nonzero, Z means the result is zero and N is the result sign. V is 0 except for opcode 1110, where it is set when both operands are negative. Example: 0xEC00 ^ 0xFFFF gives 0x13FF with V=1 and C=1.
- R9: When byte_i is 1, only bits 7:0 of the operands are used and bits 15:8 of result_o are 0. C comes from the carry out of bit 7 (or the top BCD digit of the low byte), N comes from bit 7, and V uses bit 7 as the sign.
- R10: Opcodes 0000 to 0100 give result 0, wr_en_o 0 and flag_upd_o 0000, and flags_o equals the incoming flags.
- R11: The flag vectors are laid out as bit 0 = C, bit 1 = Z, bit 2 = N, bit 3 = V. For each flag, flags_o carries the new value when the matching flag_upd_o bit is set and the incoming value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte operation, 0 selects word operation |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| flags_i | input | 4 | Incoming flags {V,N,Z,C} |
| result_o | output | 16 | Operation result |
| wr_en_o | output | 1 | The destination is written with result_o |
| flags_o | output | 4 | Next flags {V,N,Z,C} |
| flag_upd_o | output | 4 | Mask of the flags this operation updated |

## Verification
Every output is due exactly one rising edge after its inputs, because there is only one register stage between the operand inputs and the ports. The bench changes the inputs on a falling edge and reads all four outputs on the next falling edge, so each vector is checked half a cycle after the edge that registers it, and before the next vector is applied. The sweep covers every opcode in both widths, over a set of operands chosen for carry, sign, overflow and BCD digit boundaries, and with four patterns of incoming flags. Directed vectors repeat the decimal-carry and inverted-operand examples named in the requirements.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
package alu16_pkg;
  localparam logic [3:0] OP_ADD  = 4'b0101;
  localparam logic [3:0] OP_ADDC = 4'b0110;
  localparam logic [3:0] OP_SUBC = 4'b0111;
  localparam logic [3:0] OP_SUB  = 4'b1000;
  localparam logic [3:0] OP_CMP  = 4'b1001;
  localparam logic [3:0] OP_DADD = 4'b1010;
  localparam logic [3:0] OP_BIT  = 4'b1011;
  localparam logic [3:0] OP_BIC  = 4'b1100;
  localparam logic [3:0] OP_BIS  = 4'b1101;
  localparam logic [3:0] OP_XOR  = 4'b1110;
  localparam logic [3:0] OP_AND  = 4'b1111;

  // bit 0 = carry
  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;

  localparam logic [3:0] UPD_ALL  = 4'b1111;
  localparam logic [3:0] UPD_NONE = 4'b0000;
  localparam logic [3:0] UPD_CZN  = 4'b0111;
endpackage

// File: rtl/alu16_addsub.sv
`timescale 1ns/1ps
module alu16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         byte_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         v_o
);
  localparam int HALF = W / 2;

  logic [W:0] full;
  logic       a_s, b_s, r_s;

  always_comb begin
    full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o  = byte_i ? {{(W-HALF){1'b0}}, full[HALF-1:0]} : full[W-1:0];
    cout_o = byte_i ? full[HALF] : full[W];
    a_s    = byte_i ? a_i[HALF-1] : a_i[W-1];
    b_s    = byte_i ? b_i[HALF-1] : b_i[W-1];
    r_s    = byte_i ? full[HALF-1] : full[W-1];
    v_o    = (a_s == b_s) && (r_s != a_s);
  end
endmodule

// File: rtl/alu16_bcd.sv
`timescale 1ns/1ps
module alu16_bcd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         byte_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int NIB  = W / 4;
  localparam int HNIB = NIB / 2;

  logic [NIB:0] cy;
  logic [W-1:0] raw;

  assign cy[0] = cin_i;

  // ripple of decimal digits
  for (genvar g = 0; g < NIB; g++) begin : g_dig
    logic [4:0] t;
    logic       adj;
    assign t   = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0000, cy[g]};
    assign adj = (t > 5'd9);
    assign raw[4*g +: 4] = adj ? (t[3:0] + 4'd6) : t[3:0];
    assign cy[g+1] = adj;
  end

  assign sum_o  = byte_i ? {{(W-4*HNIB){1'b0}}, raw[4*HNIB-1:0]} : raw;
  assign cout_o = byte_i ? cy[HNIB] : cy[NIB];
endmodule

// File: rtl/alu16_logic.sv
`timescale 1ns/1ps
module alu16_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] clr_o,
  output logic [W-1:0] set_o
);
  assign and_o = dst_i & src_i;
  assign xor_o = dst_i ^ src_i;
  assign clr_o = dst_i & ~src_i;
  assign set_o = dst_i | src_i;
endmodule

// File: rtl/alu16_core.sv
`timescale 1ns/1ps
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   op_i,
  input  logic         byte_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic [3:0]   flags_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o,
  output logic [3:0]   flag_upd_o
);
  localparam int HALF = W / 2;

  logic [W-1:0] mask, src_m, dst_m, b_eff;
  logic         is_sub, cin;
  logic [W-1:0] add_sum, bcd_sum, and_r, xor_r, clr_r, set_r;
  logic         add_c, add_v, bcd_c;
  alu_flags_t   fin, fnew;
  logic [W-1:0] res_d;
  logic         wr_d;
  logic [3:0]   upd_d, flags_d;
  logic         zero, msb, src_s, dst_s;

  assign fin   = alu_flags_t'(flags_i);
  assign mask  = byte_i ? {{(W-HALF){1'b0}}, {HALF{1'b1}}} : {W{1'b1}};
  assign src_m = src_i & mask;
  assign dst_m = dst_i & mask;

  always_comb begin
    is_sub = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
    b_eff  = is_sub ? (~src_i & mask) : src_m;
    unique case (op_i)
      OP_SUB, OP_CMP: cin = 1'b1;
      OP_ADDC, OP_SUBC: cin = fin.c;
      default: cin = 1'b0;
    endcase
  end

  alu16_addsub #(.W(W)) u_addsub (
    .a_i(dst_m), .b_i(b_eff), .cin_i(cin), .byte_i(byte_i),
    .sum_o(add_sum), .cout_o(add_c), .v_o(add_v)
  );

  alu16_bcd #(.W(W)) u_bcd (
    .a_i(dst_m), .b_i(src_m), .cin_i(fin.c), .byte_i(byte_i),
    .sum_o(bcd_sum), .cout_o(bcd_c)
  );

  alu16_logic #(.W(W)) u_logic (
    .dst_i(dst_m), .src_i(src_m),
    .and_o(and_r), .xor_o(xor_r), .clr_o(clr_r), .set_o(set_r)
  );

  always_comb begin
    res_d = '0;
    wr_d  = 1'b0;
    upd_d = UPD_NONE;
    unique case (op_i)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin res_d = add_sum; wr_d = 1'b1; upd_d = UPD_ALL; end
      OP_CMP:  begin res_d = add_sum; upd_d = UPD_ALL; end
      OP_DADD: begin res_d = bcd_sum; wr_d = 1'b1; upd_d = UPD_CZN; end
      OP_BIT:  begin res_d = and_r; upd_d = UPD_ALL; end
      OP_AND:  begin res_d = and_r; wr_d = 1'b1; upd_d = UPD_ALL; end
      OP_XOR:  begin res_d = xor_r; wr_d = 1'b1; upd_d = UPD_ALL; end
      OP_BIC:  begin res_d = clr_r; wr_d = 1'b1; end
      OP_BIS:  begin res_d = set_r; wr_d = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    zero  = (res_d == '0);
    msb   = byte_i ? res_d[HALF-1] : res_d[W-1];
    src_s = byte_i ? src_m[HALF-1] : src_m[W-1];
    dst_s = byte_i ? dst_m[HALF-1] : dst_m[W-1];
    fnew.z = zero;
    fnew.n = msb;
    unique case (op_i)
      OP_DADD:        begin fnew.c = bcd_c; fnew.v = fin.v; end
      OP_BIT, OP_AND: begin fnew.c = ~zero; fnew.v = 1'b0; end
      OP_XOR:         begin fnew.c = ~zero; fnew.v = src_s & dst_s; end
      default:        begin fnew.c = add_c; fnew.v = add_v; end
    endcase
    flags_d = (fnew & upd_d) | (flags_i & ~upd_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o   <= '0;
      wr_en_o    <= 1'b0;
      flags_o    <= '0;
      flag_upd_o <= '0;
    end else begin
      result_o   <= res_d;
      wr_en_o    <= wr_d;
      flags_o    <= flags_d;
      flag_upd_o <= upd_d;
    end
  end
endmodule

// File: rtl/alu16_core_chk.sv
`timescale 1ns/1ps
module alu16_core_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [3:0]   op_i,
  input logic         byte_i,
  input logic [3:0]   flags_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic [3:0]   flags_o,
  input logic [3:0]   flag_upd_o
);
  localparam int HALF = W / 2;

  // R5
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == 4'b1001) |-> !wr_en_o);

  // R7
  bitset_flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(op_i) == 4'b1100 || $past(op_i) == 4'b1101))
      |-> (flag_upd_o == 4'b0000 && flags_o == $past(flags_i) && wr_en_o));

  // R9
  byte_upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(byte_i)) |-> (result_o[W-1:HALF] == '0));

  // R8
  logic_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(op_i) == 4'b1011 || $past(op_i) == 4'b1110 || $past(op_i) == 4'b1111))
      |-> (flags_o[0] == (result_o != '0) && flags_o[1] == (result_o == '0)));

  // R6
  bcd_v_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) == 4'b1010) |-> (flags_o[3] == $past(flags_i[3])));

  // R10
  unused_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i) < 4'b0101)
      |-> (!wr_en_o && flag_upd_o == 4'b0000 && result_o == '0 && flags_o == $past(flags_i)));
endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .byte_i(byte_i), .flags_i(flags_i),
  .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o), .flag_upd_o(flag_upd_o)
);

// File: tb/alu16_core_tb.sv
`timescale 1ns/1ps
module alu16_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic        bw = 1'b0;
  logic [15:0] src = '0, dst = '0;
  logic [3:0]  fin = '0;
  logic [15:0] result;
  logic        wr_en;
  logic [3:0]  flags, upd;
  int n_run = 0, n_fail = 0;
  logic [15:0] vals [12];
  logic [3:0]  fpat [4];

  always #2 clk = ~clk;

  alu16_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .byte_i(bw), .src_i(src), .dst_i(dst),
    .flags_i(fin), .result_o(result), .wr_en_o(wr_en), .flags_o(flags), .flag_upd_o(upd)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] o, input logic b);
    string t;
    case (o)
      4'b0101, 4'b0110: t = "R2 R4";
      4'b0111, 4'b1000: t = "R3 R4";
      4'b1001: t = "R5 R4";
      4'b1010: t = "R6";
      4'b1011, 4'b1110, 4'b1111: t = "R8";
      4'b1100, 4'b1101: t = "R7";
      default: t = "R10";
    endcase
    if (b) t = {t, " R9"};
    return {t, " R11"};
  endfunction

  task automatic model(input logic [3:0] o, input logic b, input logic [15:0] s_in, input logic [15:0] d_in,
                       input logic [3:0] f, output logic [15:0] r, output logic wr, output logic [3:0] fo,
                       output logic [3:0] u);
    int hb, m, s, d, e, full, cy, t, sb;
    logic c, z, n, v;
    hb = b ? 8 : 16;
    m  = (1 << hb) - 1;
    s  = int'(s_in) & m;
    d  = int'(d_in) & m;
    sb = hb - 1;
    r = '0; wr = 1'b0; u = 4'b0000;
    c = f[0]; v = f[3];
    case (o)
      4'b0101, 4'b0110, 4'b0111, 4'b1000, 4'b1001: begin
        e = (o >= 4'b0111) ? ((~s) & m) : s;
        full = d + e + ((o == 4'b0101) ? 0 : (o == 4'b0110 || o == 4'b0111) ? int'(f[0]) : 1);
        r = 16'(full & m);
        c = full[hb];
        v = (d[sb] == e[sb]) && (r[sb] != d[sb]);
        wr = (o != 4'b1001); u = 4'b1111;
      end
      4'b1010: begin
        cy = int'(f[0]); full = 0;
        for (int i = 0; i < hb / 4; i++) begin
          t = ((d >> (4*i)) & 15) + ((s >> (4*i)) & 15) + cy;
          if (t > 9) begin t = t + 6; cy = 1; end else cy = 0;
          full = full | ((t & 15) << (4*i));
        end
        r = 16'(full); c = cy[0]; wr = 1'b1; u = 4'b0111;
      end
      4'b1011, 4'b1111, 4'b1110: begin
        r = (o == 4'b1110) ? 16'(d ^ s) : 16'(d & s);
        c = (r != 0);
        v = (o == 4'b1110) ? (d[sb] && s[sb]) : 1'b0;
        wr = (o != 4'b1011); u = 4'b1111;
      end
      4'b1100: begin r = 16'(d & ~s & m); wr = 1'b1; end
      4'b1101: begin r = 16'(d | s); wr = 1'b1; end
      default: ;
    endcase
    z = (r == 0); n = r[sb];
    fo = ({v, n, z, c} & u) | (f & ~u);
  endtask

  task automatic run_vec(input logic [3:0] o, input logic b, input logic [15:0] s_in, input logic [15:0] d_in,
                         input logic [3:0] f);
    logic [15:0] er; logic ew; logic [3:0] ef, eu; string tg;
    op = o; bw = b; src = s_in; dst = d_in; fin = f;
    model(o, b, s_in, d_in, f, er, ew, ef, eu);
    @(negedge clk);
    tg = op_tag(o, b);
    chk(tg, "result", 32'(result), 32'(er));
    chk(tg, "wr_en", 32'(wr_en), 32'(ew));
    chk(tg, "flags", 32'(flags), 32'(ef));
    chk(tg, "upd", 32'(upd), 32'(eu));
  endtask

  initial begin
    vals = '{16'h0000, 16'h0001, 16'h0009, 16'h0099, 16'h007F, 16'h0080,
             16'h00FF, 16'h7FFF, 16'h8000, 16'hEC00, 16'hFFFF, 16'h1234};
    fpat = '{4'b0000, 4'b0001, 4'b1110, 4'b1111};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "result", 32'(result), 0);
    chk("R1", "wr_en", 32'(wr_en), 0);
    chk("R1", "flags", 32'(flags), 0);
    chk("R1", "upd", 32'(upd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed cases
    run_vec(4'b1010, 1'b0, 16'h0001, 16'h0009, 4'b0000);   // R6 0x9+1
    chk("R6", "bcd 9+1", 32'(result), 32'h0010);
    run_vec(4'b1010, 1'b0, 16'h0001, 16'h0099, 4'b0001);   // R6 word with carry
    chk("R6", "bcd 99+1+C word", 32'(result), 32'h0101);
    run_vec(4'b1010, 1'b1, 16'h0001, 16'h0099, 4'b0001);   // R9 byte
    chk("R9", "bcd byte result", 32'(result), 32'h0001);
    chk("R9", "bcd byte carry", 32'(flags[0]), 1);
    run_vec(4'b1110, 1'b0, 16'hFFFF, 16'hEC00, 4'b0000);   // R8
    chk("R8", "xor result", 32'(result), 32'h13FF);
    chk("R8", "xor V,C", 32'({flags[3], flags[0]}), 32'b11);
    run_vec(4'b1000, 1'b0, 16'd1, 16'd10, 4'b0000);         // R3 10-1
    chk("R3", "10-1 carry", 32'(flags[0]), 1);
    run_vec(4'b1000, 1'b0, 16'd8, 16'd5, 4'b0001);          // R3 5-8
    chk("R3", "5-8 carry", 32'(flags[0]), 0);
    // sweep
    for (int o = 0; o < 16; o++)
      for (int b = 0; b < 2; b++)
        for (int fi = 0; fi < 4; fi++)
          for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
              run_vec(4'(o), b[0], vals[i], vals[j], fpat[fi]);
    // R1 reset clears again
    rst_n = 1'b0;
    #1;
    chk("R1", "async clear", 32'({result, wr_en, flags, upd}), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule